// File: doc/BRIEF.md
# DRAM Controller Performance Counter Bank

This block sits beside a DRAM controller and gathers performance figures from it. The controller supplies a vector of single-cycle event pulses, plus the valid strobe and the transaction ID for each read and each write it accepts. Four counters turn these inputs into counts that software can read through a small register port.

Counter 0 is a fixed sample-window timer. It counts every enabled clock cycle, whatever its configuration register holds. When it runs past its all-ones value it freezes the whole bank and raises an interrupt. Software then reads the counters at leisure and writes the clear bit to start a new window.

Counters 1 to 3 each count the event named by the code in their own configuration register. Two codes count reads or writes whose ID passes a shared mask-and-compare filter. On overflow these counters wrap without any notice.

Top module: `perf_counter_bank`

## Requirements
- R1: The bank has four counters: counter 0 is TMR_W bits wide and counters 1 to 3 are CNT_W bits wide (both default 32). They read back zero-extended at register addresses 8, 9, 10 and 11, at any time, including while the bank is locked.
- R2: While the bank is enabled and not locked, counter 0 advances by one on every clock cycle, whatever code is written to its configuration register at address 4.
- R3: When counter 0 wraps from all ones to zero, the lock and the `irq` output go high on that same edge. From then on, no counter changes until a clear.
- R4: When counter 1, 2 or 3 wraps from all ones to zero, it goes on counting from zero, and neither the lock nor `irq` is set.
- R5: The configuration register of counter i (i = 1 to 3) is at address 4+i and holds an 8-bit code in bits 7:0. A code k in 1..EVT_W makes the counter add one on each cycle in which `evtPulse[k-1]` is high.
- R6: Code 0x41 counts cycles where `axiRdValid` is high and `axiRdId` passes the filter. Code 0x42 does the same with `axiWrValid` and `axiWrId`. The filter register at address 1 holds the compare ID in bits ID_W-1:0 and the mask in bits 2*ID_W-1:ID_W. An ID passes when every bit whose mask bit is 1 equals the compare ID.
- R7: Any code that is not 0x41, 0x42 or 1..EVT_W leaves the counter holding its value.
- R8: Bit 0 of the control register at address 0 is the enable. While it is 0, no counter changes.
- R9: A write to address 0 with bit 1 set zeroes all four counters, the lock and `irq` on that edge, even while counting is under way. Bit 1 is not stored.
- R10: Address 0 reads back the enable in bit 0 and the lock in bit 1. After reset, the control register, all counters and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 4 | Register write address |
| regWrData | input | DATA_W | Register write data |
| regRdAddr | input | 4 | Register read address |
| regRdData | output | DATA_W | Read data, combinational from regRdAddr |
| evtPulse | input | EVT_W | Single-cycle event pulses from the controller |
| axiRdValid | input | 1 | A read transaction is accepted this cycle |
| axiRdId | input | ID_W | ID of the accepted read |
| axiWrValid | input | 1 | A write transaction is accepted this cycle |
| axiWrId | input | ID_W | ID of the accepted write |
| irq | output | 1 | High while the bank is locked by timer expiry |

## Verification
The bench builds the bank with an 8-bit event counter width, a 9-bit timer, 4 event inputs and 8-bit IDs. With these widths an event counter overflows after 256 events and the timer expires after 512 cycles. Both events fall well inside one run. Because the timer is wider than the event counters, an event-counter wrap can be watched on its own without the lock firing first. A nibble mask in the filter lets one vector show a passing ID and another show a failing one.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int CODE_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [CODE_W-1:0] CODE_AXI_RD = 8'h41;
  localparam logic [CODE_W-1:0] CODE_AXI_WR = 8'h42;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_FILT     = 4'd1;
  localparam int                ADDR_CFG_BASE = 4;
  localparam int                ADDR_CNT_BASE = 8;

  typedef struct packed {
    logic runEn;
    logic clearAll;
  } perf_strobe_t;
endpackage

// File: rtl/perf_ctrl.sv
module perf_ctrl
  import perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regWrAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                timerWrap,
  output perf_strobe_t        strobe,
  output logic [CODE_W-1:0]   cfgCode [NUM_CNT],
  output logic [ID_W-1:0]     filtId,
  output logic [ID_W-1:0]     filtMask,
  output logic                enableQ,
  output logic                lockQ
);
  logic ctrlWr;
  logic filtWr;

  assign ctrlWr = regWrEn && (regWrAddr == ADDR_CTRL);
  assign filtWr = regWrEn && (regWrAddr == ADDR_FILT);

  assign strobe.clearAll = ctrlWr && regWrData[1];
  assign strobe.runEn    = enableQ && !lockQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      lockQ   <= 1'b0;
    end else begin
      if (ctrlWr) enableQ <= regWrData[0];
      if (strobe.clearAll) lockQ <= 1'b0;
      else if (timerWrap) lockQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtId   <= '0;
      filtMask <= '0;
    end else if (filtWr) begin
      filtId   <= regWrData[ID_W-1:0];
      filtMask <= regWrData[2*ID_W-1:ID_W];
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgCode[g] <= '0;
      else if (regWrEn && (regWrAddr == ADDR_W'(ADDR_CFG_BASE + g)))
        cfgCode[g] <= regWrData[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/perf_datapath.sv
module perf_datapath
  import perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int TMR_W   = 32,
  parameter int EVT_W   = 16,
  parameter int ID_W    = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  perf_strobe_t                 strobe,
  input  logic [CODE_W-1:0]            cfgCode [NUM_CNT],
  input  logic [ID_W-1:0]              filtId,
  input  logic [ID_W-1:0]              filtMask,
  input  logic [EVT_W-1:0]             evtPulse,
  input  logic                         axiRdValid,
  input  logic [ID_W-1:0]              axiRdId,
  input  logic                         axiWrValid,
  input  logic [ID_W-1:0]              axiWrId,
  output logic                         timerWrap,
  output logic [TMR_W-1:0]             timerVal,
  output logic [NUM_CNT-1:1][CNT_W-1:0] evtCnt
);
  logic rdHit;
  logic wrHit;

  assign rdHit = axiRdValid && (((axiRdId ^ filtId) & filtMask) == '0);
  assign wrHit = axiWrValid && (((axiWrId ^ filtId) & filtMask) == '0);

  assign timerWrap = strobe.runEn && (&timerVal) && !strobe.clearAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerVal <= '0;
    else if (strobe.clearAll) timerVal <= '0;
    else if (strobe.runEn) timerVal <= timerVal + 1'b1;
  end

  for (genvar g = 1; g < NUM_CNT; g++) begin : g_evt
    logic hit;

    always_comb begin
      hit = 1'b0;
      if (cfgCode[g] == CODE_AXI_RD) hit = rdHit;
      else if (cfgCode[g] == CODE_AXI_WR) hit = wrHit;
      else begin
        for (int k = 0; k < EVT_W; k++)
          if (cfgCode[g] == CODE_W'(k + 1)) hit = evtPulse[k];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtCnt[g] <= '0;
      else if (strobe.clearAll) evtCnt[g] <= '0;
      else if (strobe.runEn && hit) evtCnt[g] <= evtCnt[g] + 1'b1;
    end
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int TMR_W   = 32,
  parameter int EVT_W   = 16,
  parameter int ID_W    = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [3:0]        regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  input  logic [EVT_W-1:0]  evtPulse,
  input  logic              axiRdValid,
  input  logic [ID_W-1:0]   axiRdId,
  input  logic              axiWrValid,
  input  logic [ID_W-1:0]   axiWrId,
  output logic              irq
);
  perf_strobe_t              strobe;
  logic [CODE_W-1:0]         cfgCode [NUM_CNT];
  logic [ID_W-1:0]           filtId;
  logic [ID_W-1:0]           filtMask;
  logic                      enableQ;
  logic                      lockQ;
  logic                      timerWrap;
  logic [TMR_W-1:0]          timerVal;
  logic [NUM_CNT-1:1][CNT_W-1:0] evtCnt;
  logic [NUM_CNT-1:0][DATA_W-1:0] cntAll;

  perf_ctrl #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W), .ID_W(ID_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .timerWrap(timerWrap), .strobe(strobe),
    .cfgCode(cfgCode), .filtId(filtId), .filtMask(filtMask),
    .enableQ(enableQ), .lockQ(lockQ)
  );

  perf_datapath #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .TMR_W(TMR_W),
                  .EVT_W(EVT_W), .ID_W(ID_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgCode(cfgCode),
    .filtId(filtId), .filtMask(filtMask), .evtPulse(evtPulse),
    .axiRdValid(axiRdValid), .axiRdId(axiRdId),
    .axiWrValid(axiWrValid), .axiWrId(axiWrId),
    .timerWrap(timerWrap), .timerVal(timerVal), .evtCnt(evtCnt)
  );

  assign irq = lockQ;

  assign cntAll[0] = DATA_W'(timerVal);
  for (genvar g = 1; g < NUM_CNT; g++) begin : g_cnt
    assign cntAll[g] = DATA_W'(evtCnt[g]);
  end

  always_comb begin
    regRdData = '0;
    if (regRdAddr == ADDR_CTRL) regRdData = DATA_W'({lockQ, enableQ});
    else if (regRdAddr == ADDR_FILT) regRdData = DATA_W'({filtMask, filtId});
    for (int i = 0; i < NUM_CNT; i++) begin
      if (regRdAddr == ADDR_W'(ADDR_CFG_BASE + i)) regRdData = DATA_W'(cfgCode[i]);
      if (regRdAddr == ADDR_W'(ADDR_CNT_BASE + i)) regRdData = cntAll[i];
    end
  end
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int NUM_CNT = 4,
  parameter int TMR_W   = 32,
  parameter int DATA_W  = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWrEn,
  input logic [3:0]                    regWrAddr,
  input logic [DATA_W-1:0]             regWrData,
  input logic                          enableQ,
  input logic                          lockQ,
  input logic                          irq,
  input logic [TMR_W-1:0]              timerVal,
  input logic [NUM_CNT-1:0][DATA_W-1:0] cntAll
);
  logic wrClr;
  assign wrClr = regWrEn && (regWrAddr == 4'd0) && regWrData[1];

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && !lockQ && !wrClr) |=> (timerVal == TMR_W'($past(timerVal) + 1'b1))); // R2

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !wrClr) |=> $stable(cntAll)); // R3

  AST_IRQ_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (timerVal == '0 && &($past(timerVal)))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ && !wrClr) |=> $stable(cntAll)); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> (cntAll == '0 && !irq)); // R9
endmodule

bind perf_counter_bank perf_counter_bank_chk #(
  .NUM_CNT(NUM_CNT), .TMR_W(TMR_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb_top;
  localparam int CNT_W = 8, TMR_W = 9, EVT_W = 4, ID_W = 8, DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regWrAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [3:0] regRdAddr = '0;
  logic [DATA_W-1:0] regRdData;
  logic [EVT_W-1:0] evtPulse = '0;
  logic axiRdValid = 1'b0;
  logic [ID_W-1:0] axiRdId = '0;
  logic axiWrValid = 1'b0;
  logic [ID_W-1:0] axiWrId = '0;
  logic irq;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  perf_counter_bank #(.CNT_W(CNT_W), .TMR_W(TMR_W), .EVT_W(EVT_W),
                      .ID_W(ID_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .evtPulse(evtPulse), .axiRdValid(axiRdValid), .axiRdId(axiRdId),
    .axiWrValid(axiWrValid), .axiWrId(axiWrId), .irq(irq)
  );

  // code, evt, rdV, rdId, wrV, wrId, cycles, expected count on counter 1
  localparam logic [45:0] VEC [10] = '{
    {8'h01, 4'b0001, 1'b0, 8'h00, 1'b0, 8'h00, 8'd10, 8'd10},
    {8'h02, 4'b0010, 1'b0, 8'h00, 1'b0, 8'h00, 8'd7,  8'd7},
    {8'h01, 4'b0010, 1'b0, 8'h00, 1'b0, 8'h00, 8'd5,  8'd0},
    {8'h41, 4'b0000, 1'b1, 8'h15, 1'b0, 8'h00, 8'd6,  8'd6},
    {8'h41, 4'b0000, 1'b1, 8'h25, 1'b0, 8'h00, 8'd6,  8'd0},
    {8'h41, 4'b0000, 1'b0, 8'h12, 1'b0, 8'h00, 8'd4,  8'd0},
    {8'h42, 4'b0000, 1'b0, 8'h00, 1'b1, 8'h1F, 8'd9,  8'd9},
    {8'h42, 4'b0000, 1'b1, 8'h12, 1'b0, 8'h12, 8'd8,  8'd0},
    {8'h07, 4'b1111, 1'b0, 8'h00, 1'b0, 8'h00, 8'd8,  8'd0},
    {8'h04, 4'b1000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd12, 8'd12}
  };

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wrReg(input logic [3:0] addr, input logic [DATA_W-1:0] data);
    regWrEn = 1'b1; regWrAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] addr, output logic [DATA_W-1:0] data);
    regRdAddr = addr;
    #1;
    data = regRdData;
  endtask

  task automatic stimOff();
    evtPulse = '0; axiRdValid = 1'b0; axiRdId = '0; axiWrValid = 1'b0; axiWrId = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    rdReg(4'd0, v); check("R10 ctrl after reset", v, 0);
    rdReg(4'd8, v); check("R10 counter0 after reset", v, 0);
    rdReg(4'd9, v); check("R10 counter1 after reset", v, 0);
    check("R10 irq after reset", DATA_W'(irq), 0);

    // R6 filter: compare upper nibble only, id 0x12
    wrReg(4'd1, 32'h0000_F012);
    rdReg(4'd1, v); check("R6 filter readback", v, 32'h0000_F012);

    // R5 R6 R7 vector table on counter 1
    for (int n = 0; n < 10; n++) begin
      logic [45:0] e;
      e = VEC[n];
      wrReg(4'd0, 32'd2);
      wrReg(4'd5, DATA_W'(e[45:38]));
      wrReg(4'd0, 32'd1);
      evtPulse = e[37:34]; axiRdValid = e[33]; axiRdId = e[32:25];
      axiWrValid = e[24]; axiWrId = e[23:16];
      repeat (int'(e[15:8])) @(negedge clk);
      stimOff();
      wrReg(4'd0, 32'd0);
      rdReg(4'd9, v);
      check($sformatf("R5/R6/R7 vector %0d code 0x%0h", n, e[45:38]), v, DATA_W'(e[7:0]));
    end

    // R2 counter 0 ignores its config code
    wrReg(4'd0, 32'd2);
    wrReg(4'd4, 32'h41);
    wrReg(4'd0, 32'd1);
    repeat (19) @(negedge clk);
    wrReg(4'd0, 32'd0);
    rdReg(4'd8, v); check("R2 counter0 counts cycles", v, 20);

    // R8 disabled bank does not count
    wrReg(4'd0, 32'd2);
    wrReg(4'd5, 32'd1);
    evtPulse = 4'b0001;
    repeat (10) @(negedge clk);
    stimOff();
    rdReg(4'd9, v); check("R8 counter1 while disabled", v, 0);
    rdReg(4'd8, v); check("R8 counter0 while disabled", v, 0);

    // R4 counter 1 wraps silently
    wrReg(4'd0, 32'd1);
    evtPulse = 4'b0001;
    repeat (300) @(negedge clk);
    stimOff();
    wrReg(4'd0, 32'd0);
    rdReg(4'd9, v); check("R4 counter1 after wrap", v, 44);
    check("R4 no irq on event wrap", DATA_W'(irq), 0);
    rdReg(4'd0, v); check("R4 no lock on event wrap", v, 0);

    // R3 R1 timer expiry locks bank
    wrReg(4'd0, 32'd2);
    wrReg(4'd6, 32'd2);
    wrReg(4'd0, 32'd1);
    evtPulse = 4'b0010;
    repeat (10) @(negedge clk);
    stimOff();
    repeat (520) @(negedge clk);
    check("R3 irq after expiry", DATA_W'(irq), 1);
    rdReg(4'd0, v); check("R10 ctrl shows lock", v, 3);
    rdReg(4'd8, v); check("R3 counter0 wrapped to zero", v, 0);
    rdReg(4'd10, v); check("R1 counter2 readable while locked", v, 10);
    evtPulse = 4'b0010;
    repeat (20) @(negedge clk);
    stimOff();
    rdReg(4'd10, v); check("R3 counter2 frozen", v, 10);
    rdReg(4'd8, v); check("R3 counter0 frozen", v, 0);

    // R9 clear releases lock and zeroes counters
    wrReg(4'd0, 32'd2);
    check("R9 irq cleared", DATA_W'(irq), 0);
    rdReg(4'd0, v); check("R9 ctrl after clear", v, 0);
    rdReg(4'd10, v); check("R9 counter2 zeroed", v, 0);
    rdReg(4'd8, v); check("R9 counter0 zeroed", v, 0);

    // R9 clear while counting
    wrReg(4'd0, 32'd1);
    repeat (5) @(negedge clk);
    wrReg(4'd0, 32'd2);
    rdReg(4'd8, v); check("R9 clear while counting", v, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule